// File: doc/BRIEF.md
# Gated Beam Position Capture

This block freezes a free-running horizontal and vertical beam position into a pair of holding registers when asked to. Software can ask in two ways: by strobing a read of a dedicated capture-request register, or by writing a 0 into bit 7 of a general I/O port register. That port bit is also the capture enable. Dropping it to 0 takes one capture and then locks the holding registers until software writes the bit back to 1.

Captures that come from the port write are taken a fixed number of master cycles later than captures that come from a read in the same bus cycle. This models the extra path from the port to the capture logic. Each capture also raises a sticky status flag. A read of the status register clears the flag, but only while the enable bit is 1. While capture is locked, the flag holds until software writes the enable bit back to 1. One clock of `clk_i` is one master cycle, and the position counters arrive from outside.

Top module: `hv_pos_latch`

## Requirements
- R1: On reset the enable bit (I/O port bit 7) reads 1, the capture flag is 0, and both held positions are 0.
- R2: A capture-request read strobe in a cycle where the enable bit is 1 loads the held H and V values with the counter values presented in that same cycle. The new values are visible after that clock edge.
- R3: A port write with data bit 7 = 0 while the enable bit is 1 clears the enable bit at that edge and leaves the held values unchanged at that edge.
- R4: A capture triggered by the R3 write samples the counters presented WR_DLY (default 4) cycles after the write cycle. The held values stay unchanged in the cycles between.
- R5: While the enable bit is 0, capture-request read strobes and further port writes of bit 7 = 0 leave the held values and the flag unchanged.
- R6: A port write with bit 7 = 1 sets the enable bit and does not load the held values.
- R7: Every capture, whether from a read or from a write, sets the capture flag to 1.
- R8: A status read strobe while the enable bit is 1 clears the flag. If a capture lands in the same cycle, the flag ends up 1.
- R9: A status read strobe while the enable bit is 0 leaves the flag at 1. After the enable bit is written to 1, a status read clears the flag.
- R10: A read strobe and a port write of bit 7 = 0 in the same enabled cycle both take effect. The read captures at once, and the write captures again WR_DLY cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, one beat per master cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_cnt_i | input | POS_W | Running horizontal position |
| v_cnt_i | input | POS_W | Running vertical position |
| req_rd_i | input | 1 | Read strobe of the capture-request register |
| port_wr_i | input | 1 | Write strobe of the I/O port register |
| port_wdat7_i | input | 1 | Bit 7 of the port write data |
| stat_rd_i | input | 1 | Read strobe of the status register |
| en_o | output | 1 | Current enable bit (port bit 7) |
| h_lat_o | output | POS_W | Held horizontal position |
| v_lat_o | output | POS_W | Held vertical position |
| flag_o | output | 1 | Sticky capture flag (status bit 6) |

## Verification
Two cases can land in one cycle, and the bench provokes each with a single stimulus. In the first, a capture meets a clearing status read. The flag is set, then a capture-request read and a status read are driven together; the flag must end up 1 and the held values must hold the counters of that cycle. In the second, a read capture meets a locking port write. Both strobes are driven at once; the bench expects the read-time counters at once, unchanged values for the next WR_DLY-1 cycles, and then the counters of the cycle WR_DLY after the write.

// File: rtl/hv_pos_latch_pkg.sv
package hv_pos_latch_pkg;
  localparam int unsigned AXES = 2;  // index 0: horizontal, 1: vertical

  typedef enum logic [1:0] {
    CAP_NONE  = 2'd0,
    CAP_READ  = 2'd1,
    CAP_WRITE = 2'd2
  } cap_src_e;
endpackage

// File: rtl/hv_cap_gate.sv
module hv_cap_gate
  import hv_pos_latch_pkg::*;
#(
  parameter int unsigned WR_DLY = 4  // must be >= 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_rd_i,
  input  logic     port_wr_i,
  input  logic     port_wdat7_i,
  output logic     en_o,
  output cap_src_e src_o
);
  localparam int unsigned CW = $clog2(WR_DLY + 1);
  localparam logic [CW-1:0] DLY_LD = CW'(WR_DLY);
  localparam logic [CW-1:0] DLY_ONE = CW'(1);

  logic          en_q;
  logic [CW-1:0] dly_q;
  logic          wr_lock, wr_open, wr_fire, rd_fire;

  assign wr_lock = port_wr_i & ~port_wdat7_i & en_q;
  assign wr_open = port_wr_i & port_wdat7_i;
  assign wr_fire = (dly_q == DLY_ONE);
  assign rd_fire = req_rd_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b1;
    end else if (wr_lock) begin
      en_q <= 1'b0;
    end else if (wr_open) begin
      en_q <= 1'b1;
    end
  end

  // pending write capture, counts down to the sampling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
    end else if (wr_lock) begin
      dly_q <= DLY_LD;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - DLY_ONE;
    end
  end

  always_comb begin
    src_o = CAP_NONE;
    if (wr_fire) begin
      src_o = CAP_WRITE;
    end else if (rd_fire) begin
      src_o = CAP_READ;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/hv_pos_hold.sv
module hv_pos_hold
  import hv_pos_latch_pkg::*;
#(
  parameter int unsigned POS_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [POS_W-1:0] pos_i [AXES],
  output logic [POS_W-1:0] pos_o [AXES]
);
  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic [POS_W-1:0] hold_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q <= '0;
      end else if (cap_i) begin
        hold_q <= pos_i[a];
      end
    end
    assign pos_o[a] = hold_q;
  end
endmodule

// File: rtl/hv_cap_flag.sv
module hv_cap_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic en_i,
  input  logic stat_rd_i,
  output logic flag_o
);
  logic flag_q;

  // set beats clear; clear only while enabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (cap_i) begin
      flag_q <= 1'b1;
    end else if (stat_rd_i && en_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/hv_pos_latch.sv
module hv_pos_latch
  import hv_pos_latch_pkg::*;
#(
  parameter int unsigned POS_W  = 9,
  parameter int unsigned WR_DLY = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] h_cnt_i,
  input  logic [POS_W-1:0] v_cnt_i,
  input  logic             req_rd_i,
  input  logic             port_wr_i,
  input  logic             port_wdat7_i,
  input  logic             stat_rd_i,
  output logic             en_o,
  output logic [POS_W-1:0] h_lat_o,
  output logic [POS_W-1:0] v_lat_o,
  output logic             flag_o
);
  cap_src_e         src;
  logic             cap;
  logic             en;
  logic [POS_W-1:0] pos_in  [AXES];
  logic [POS_W-1:0] pos_out [AXES];

  assign cap       = (src != CAP_NONE);
  assign pos_in[0] = h_cnt_i;
  assign pos_in[1] = v_cnt_i;

  hv_cap_gate #(.WR_DLY(WR_DLY)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_rd_i    (req_rd_i),
    .port_wr_i   (port_wr_i),
    .port_wdat7_i(port_wdat7_i),
    .en_o        (en),
    .src_o       (src)
  );

  hv_pos_hold #(.POS_W(POS_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap),
    .pos_i (pos_in),
    .pos_o (pos_out)
  );

  hv_cap_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .en_i     (en),
    .stat_rd_i(stat_rd_i),
    .flag_o   (flag_o)
  );

  assign en_o    = en;
  assign h_lat_o = pos_out[0];
  assign v_lat_o = pos_out[1];
endmodule

// File: rtl/hv_pos_latch_chk.sv
module hv_pos_latch_chk #(
  parameter int unsigned POS_W  = 9,
  parameter int unsigned WR_DLY = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [POS_W-1:0] h_cnt_i,
  input logic [POS_W-1:0] v_cnt_i,
  input logic             req_rd_i,
  input logic             port_wr_i,
  input logic             port_wdat7_i,
  input logic             stat_rd_i,
  input logic             en_o,
  input logic [POS_W-1:0] h_lat_o,
  input logic [POS_W-1:0] v_lat_o,
  input logic             flag_o
);
  localparam int unsigned AW = $clog2(WR_DLY + 1) + 1;
  localparam logic [AW-1:0] AGE_IDLE = AW'(WR_DLY);
  localparam logic [AW-1:0] AGE_FIRE = AW'(WR_DLY - 1);

  // cycles since an accepted locking write, saturating
  logic [AW-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= AGE_IDLE;
    end else if (en_o && port_wr_i && !port_wdat7_i) begin
      age_q <= '0;
    end else if (age_q < AGE_IDLE) begin
      age_q <= age_q + AW'(1);
    end
  end

  p_rd_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && req_rd_i && age_q != AGE_FIRE) |=>
      (h_lat_o == $past(h_cnt_i) && v_lat_o == $past(v_cnt_i)));

  p_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && port_wr_i && !port_wdat7_i) |=> !en_o);

  p_wr_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == AGE_FIRE) |=>
      (h_lat_o == $past(h_cnt_i) && v_lat_o == $past(v_cnt_i)));

  p_locked_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && age_q == AGE_IDLE) |=>
      ($stable(h_lat_o) && $stable(v_lat_o) && $stable(flag_o)));

  p_reopen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr_i && port_wdat7_i && age_q == AGE_IDLE && !req_rd_i) |=>
      (en_o && $stable(h_lat_o) && $stable(v_lat_o)));

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_o && req_rd_i) || age_q == AGE_FIRE) |=> flag_o);

  p_flag_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && stat_rd_i && !req_rd_i && age_q != AGE_FIRE) |=> !flag_o);

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !en_o) |=> flag_o);
endmodule

bind hv_pos_latch hv_pos_latch_chk #(.POS_W(POS_W), .WR_DLY(WR_DLY)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .h_cnt_i     (h_cnt_i),
  .v_cnt_i     (v_cnt_i),
  .req_rd_i    (req_rd_i),
  .port_wr_i   (port_wr_i),
  .port_wdat7_i(port_wdat7_i),
  .stat_rd_i   (stat_rd_i),
  .en_o        (en_o),
  .h_lat_o     (h_lat_o),
  .v_lat_o     (v_lat_o),
  .flag_o      (flag_o)
);

// File: tb/hv_pos_latch_bench.sv
`timescale 1ns/1ps
module hv_pos_latch_bench;
  localparam int unsigned POS_W  = 9;
  localparam int unsigned WR_DLY = 4;
  localparam real         T_CLK  = 8.0;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [POS_W-1:0] h_cnt = '0, v_cnt = '0;
  logic             req_rd = 1'b0, port_wr = 1'b0, port_wd7 = 1'b0, stat_rd = 1'b0;
  logic             en;
  logic [POS_W-1:0] h_lat, v_lat;
  logic             flag;

  int checks = 0;
  int failures = 0;
  logic [POS_W-1:0] h_cur = '0, v_cur = '0;

  always #(T_CLK / 2.0) clk = ~clk;

  hv_pos_latch #(.POS_W(POS_W), .WR_DLY(WR_DLY)) u_hv_pos_latch (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .h_cnt_i     (h_cnt),
    .v_cnt_i     (v_cnt),
    .req_rd_i    (req_rd),
    .port_wr_i   (port_wr),
    .port_wdat7_i(port_wd7),
    .stat_rd_i   (stat_rd),
    .en_o        (en),
    .h_lat_o     (h_lat),
    .v_lat_o     (v_lat),
    .flag_o      (flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one master cycle: counters advance, strobes held for this cycle only
  task automatic step(input logic rd, input logic wr, input logic wd7, input logic srd);
    @(negedge clk);
    h_cur    = h_cur + POS_W'(1);
    v_cur    = v_cur + POS_W'(3);
    h_cnt    = h_cur;
    v_cnt    = v_cur;
    req_rd   = rd;
    port_wr  = wr;
    port_wd7 = wd7;
    stat_rd  = srd;
    @(posedge clk);
    #1;
    req_rd  = 1'b0;
    port_wr = 1'b0;
    stat_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 en", en, 1);
    chk("R1 flag", flag, 0);
    chk("R1 h", h_lat, 0);
    chk("R1 v", v_lat, 0);
  endtask

  task automatic t_read_cap;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 h", h_lat, h_cur);
    chk("R2 v", v_lat, v_cur);
    chk("R7 flag after read", flag, 1);
    h_cur = POS_W'(9'h1FC);
    v_cur = POS_W'(9'h0F0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 h near top", h_lat, h_cur);
    chk("R2 v near top", v_lat, v_cur);
  endtask

  task automatic t_stat_clear;
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 clear", flag, 0);
  endtask

  task automatic t_write_cap;
    logic [POS_W-1:0] ph, pv;
    ph = h_lat;
    pv = v_lat;
    step(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 en low", en, 0);
    chk("R3 h unchanged", h_lat, ph);
    for (int i = 1; i < WR_DLY; i++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R4 h before delay", h_lat, ph);
      chk("R4 v before delay", v_lat, pv);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 h delayed", h_lat, h_cur);
    chk("R4 v delayed", v_lat, v_cur);
    chk("R7 flag after write", flag, 1);
  endtask

  task automatic t_locked;
    logic [POS_W-1:0] ph, pv;
    ph = h_lat;
    pv = v_lat;
    step(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 rd ignored h", h_lat, ph);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    idle(WR_DLY + 1);
    chk("R5 wr0 ignored h", h_lat, ph);
    chk("R5 wr0 ignored v", v_lat, pv);
    chk("R5 en stays low", en, 0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 flag sticky", flag, 1);
  endtask

  task automatic t_reenable;
    logic [POS_W-1:0] ph;
    ph = h_lat;
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6 en high", en, 1);
    chk("R6 no capture", h_lat, ph);
    idle(WR_DLY + 1);
    chk("R6 no late capture", h_lat, ph);
    chk("R9 flag held to reenable", flag, 1);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9 clear after reenable", flag, 0);
  endtask

  task automatic t_collide_flag;
    step(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R8 set wins", flag, 1);
    chk("R8 h captured", h_lat, h_cur);
  endtask

  task automatic t_rd_and_wr;
    logic [POS_W-1:0] nh, nv;
    step(1'b1, 1'b1, 1'b0, 1'b0);
    nh = h_cur;
    nv = v_cur;
    chk("R10 read part h", h_lat, nh);
    chk("R10 read part v", v_lat, nv);
    chk("R10 locked", en, 0);
    idle(WR_DLY - 1);
    chk("R10 held between", h_lat, nh);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R10 write part h", h_lat, h_cur);
    chk("R10 write part v", v_lat, v_cur);
  endtask

  initial begin
    #(T_CLK * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(T_CLK * 2.25);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_read_cap();
    t_stat_clear();
    t_write_cap();
    t_locked();
    t_reenable();
    t_collide_flag();
    t_rd_and_wr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule